// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address stream for a four-beat read burst in a synchronous SRAM. On a rising clock edge where the load enable is high, it captures a full start address from the external bus. Each later edge where the advance input is high steps an internal two-bit beat count. The block then derives the next three addresses itself by rearranging only the two least significant address bits. The upper address bits keep the value that was captured.

Two beat orderings are available. The interleaved order XORs the captured low bits with the beat count. The linear order adds the beat count to the captured low bits, modulo four. The order input is sampled at each load, so an ordering chosen at the start of a burst stays fixed to its end. A load on any edge starts a new burst at once, which allows back-to-back accesses. The address output, beat index and status flags all come from registers, so they are valid one clock after the edge that changed them.

Top module: `sram_burst_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle after that edge: `busy`=0, `beat_idx`=0, `last_beat`=0 and `addr_out`=0.
- R2: After an edge with `load_en`=1, `addr_out` equals the `start_addr` sampled at that edge, `beat_idx`=0 and `busy`=1. This holds whether or not a burst was already running.
- R3: When the order captured at load is interleaved (`order_sel`=1), the low two bits of `addr_out` equal the captured low bits XOR `beat_idx`. From start 01 this gives 01,00,11,10.
- R4: When the order captured at load is linear (`order_sel`=0), the low two bits of `addr_out` equal (captured low bits + `beat_idx`) mod 4. From start 01 this gives 01,10,11,00.
- R5: Bits `ADDR_W-1:2` of `addr_out` hold the captured start address and do not change until the next load.
- R6: `advance` increments `beat_idx` by one only while `busy`=1. While idle it has no effect: `beat_idx` and `addr_out` stay the same.
- R7: An advance taken at beat 3 wraps `beat_idx` to 0, and the address sequence repeats from the captured start.
- R8: When `load_en` and `advance` are both high at the same edge, the load wins: `beat_idx` becomes 0 and `addr_out` equals the new start address.
- R9: A change of `order_sel` between loads has no effect on the running burst's ordering.
- R10: `last_beat` is 1 exactly when `busy`=1 and `beat_idx`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Enable; capture `start_addr` at this edge |
| start_addr | input | ADDR_W | External start word address |
| advance | input | 1 | Step to the next beat of the running burst |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order; sampled on load |
| addr_out | output | ADDR_W | Current word address |
| beat_idx | output | 2 | Position within the burst, 0..3 |
| busy | output | 1 | A burst has been loaded since reset |
| last_beat | output | 1 | Fourth beat of the burst is presented |

## Verification
Full bursts are run from all four low start values in both orderings. The two orders agree from starts 00 and 10 but differ from 01 and 11, so only the odd starts can show that the wrong order was picked. Directed cases cover advance while idle, a load and an advance on the same edge, a flip of the order input in mid-burst, wrap past the fourth beat, and upper bits that are all ones or alternating. These separate a counter that is never gated from one that is gated correctly, and a live order input from one that is latched. A long run of random load, advance and order patterns with random upper bits then compares every cycle against a reference model in the bench.

// File: rtl/sbs_pkg.sv
// Package: shared constants and types for the burst address sequencer.
// Assumes a fixed four-beat burst, so the beat count is two bits wide.
package sbs_pkg;
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/sbs_start_reg.sv
// Module: sbs_start_reg
// Holds the captured start address (upper and low parts), the ordering
// chosen at load, and the burst-active flag.
// Assumes: a synchronous active-low reset; a load may occur on any edge.
module sbs_start_reg
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              order_sel,
    output logic [ADDR_W-BEAT_W-1:0] upper_q,
    output beat_t             low_q,
    output burst_order_e      order_q,
    output logic              active_q
);
    // Capture the start address and ordering on load; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q  <= '0;
            low_q    <= '0;
            order_q  <= ORD_LINEAR;
            active_q <= 1'b0;
        end else if (load_en) begin
            upper_q  <= start_addr[ADDR_W-1:BEAT_W];
            low_q    <= start_addr[BEAT_W-1:0];
            order_q  <= burst_order_e'(order_sel);
            active_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sbs_beat_ctr.sv
// Module: sbs_beat_ctr
// Beat counter for one burst. Load clears it. Advance steps it only while a
// burst is active. It wraps naturally from the last beat back to zero.
// Assumes: load takes priority over advance.
module sbs_beat_ctr
    import sbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_en,
    input  logic  advance,
    input  logic  active,
    output beat_t beat_q,
    output logic  at_last
);
    localparam beat_t LAST_BEAT = beat_t'(BURST_LEN - 1);

    // Count beats: clear on reset or load, step on a gated advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_en) begin
            beat_q <= '0;
        end else if (advance && active) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end

    // Flag the final beat of an active burst.
    always_comb begin
        at_last = active && (beat_q == LAST_BEAT);
    end
endmodule

// File: rtl/sbs_order_map.sv
// Module: sbs_order_map
// Maps the captured low bits and the beat count to the low address bits of
// the current beat. A generate block builds one mapping per order kind, and a
// mux picks between them using the order captured at load.
// Assumes: purely combinational; the inputs come from registers.
module sbs_order_map
    import sbs_pkg::*;
(
    input  beat_t        base_low,
    input  beat_t        beat,
    input  burst_order_e order,
    output beat_t        addr_low
);
    beat_t cand [2];

    for (genvar k = 0; k < 2; k++) begin : g_order
        if (k == int'(ORD_INTERLEAVE)) begin : g_xor
            // Interleaved order: flip the start bits by the beat count.
            always_comb cand[k] = base_low ^ beat;
        end else begin : g_add
            // Linear order: add the beat count and wrap modulo the burst.
            always_comb cand[k] = base_low + beat;
        end
    end

    // Select the mapping chosen for this burst.
    always_comb begin
        addr_low = cand[int'(order)];
    end
endmodule

// File: rtl/sram_burst_seq.sv
// Module: sram_burst_seq (top)
// Sequences the word addresses of a four-beat SRAM read burst. The first
// address comes from outside; the rest come from reordering the low two bits.
// Assumes: synchronous active-low reset; order_sel is sampled only on load.
module sram_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_idx,
    output logic              busy,
    output logic              last_beat
);
    logic [ADDR_W-BEAT_W-1:0] upper_q;
    beat_t                    low_q;
    burst_order_e             order_q;
    logic                     active_q;
    beat_t                    beat_q;
    beat_t                    low_now;
    logic                     at_last;

    sbs_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .start_addr (start_addr),
        .order_sel  (order_sel),
        .upper_q    (upper_q),
        .low_q      (low_q),
        .order_q    (order_q),
        .active_q   (active_q)
    );

    sbs_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .advance (advance),
        .active  (active_q),
        .beat_q  (beat_q),
        .at_last (at_last)
    );

    sbs_order_map u_map (
        .base_low (low_q),
        .beat     (beat_q),
        .order    (order_q),
        .addr_low (low_now)
    );

    // Join the held upper bits to the sequenced low bits, and drive status.
    always_comb begin
        addr_out  = {upper_q, low_now};
        beat_idx  = beat_q;
        busy      = active_q;
        last_beat = at_last;
    end
endmodule

// File: rtl/sbs_checker.sv
// Module: sbs_checker
// Temporal checks on the sequencer ports, attached to the top through bind.
// Assumes: the same clock and active-low synchronous reset as the design.
module sbs_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic [ADDR_W-1:0] start_addr,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx,
    input logic              busy,
    input logic              last_beat
);
    logic mode_seen;

    // Track the order taken at each load, for use by the step checks.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_seen <= 1'b0;
        else if (load_en) mode_seen <= order_sel;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && beat_idx == 2'd0 && !last_beat && addr_out == '0)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (addr_out == $past(start_addr) && beat_idx == 2'd0 && busy)); // R2

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && !load_en && mode_seen) |=>
        ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_idx ^ $past(beat_idx)))); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && !load_en && !mode_seen) |=>
        (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R4

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(addr_out[ADDR_W-1:2])); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en) |=> ($stable(beat_idx) && $stable(addr_out))); // R6

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && !load_en && beat_idx == 2'd3) |=> (beat_idx == 2'd0)); // R7

    AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> (busy && beat_idx == 2'd3)); // R10
endmodule

bind sram_burst_seq sbs_checker #(.ADDR_W(ADDR_W)) u_sbs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .start_addr (start_addr),
    .advance    (advance),
    .order_sel  (order_sel),
    .addr_out   (addr_out),
    .beat_idx   (beat_idx),
    .busy       (busy),
    .last_beat  (last_beat)
);

// File: tb/tb_sram_burst_seq.sv
`timescale 1ns/1ps
module tb_sram_burst_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_en;
    logic [AW-1:0] start_addr;
    logic          advance;
    logic          order_sel;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;
    logic          busy;
    logic          last_beat;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state
    logic [AW-3:0] m_up;
    logic [1:0]    m_lo, m_cnt;
    logic          m_ord, m_busy;

    always #10 clk = ~clk; // 50 MHz

    sram_burst_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .start_addr(start_addr),
        .advance(advance), .order_sel(order_sel), .addr_out(addr_out),
        .beat_idx(beat_idx), .busy(busy), .last_beat(last_beat)
    );

    function automatic logic [1:0] exp_low(input logic [1:0] b, input logic [1:0] c,
                                           input logic ord);
        return ord ? (b ^ c) : 2'(b + c);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_up, exp_low(m_lo, m_cnt, m_ord)};
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " addr"}, addr_out, exp_addr());
        chk({tag, " beat"}, AW'(beat_idx), AW'(m_cnt));
        chk({tag, " busy"}, AW'(busy), AW'(m_busy));
        chk({tag, " R10 last"}, AW'(last_beat), AW'(m_busy && m_cnt == 2'd3));
    endtask

    // One clock: drive, let the edge pass, update the model, then compare.
    task automatic step(input logic ld, input logic [AW-1:0] a, input logic adv,
                        input logic ord, input string tag);
        load_en = ld; start_addr = a; advance = adv; order_sel = ord;
        @(posedge clk);
        #2;
        if (!rst_n) begin
            m_up = '0; m_lo = '0; m_cnt = '0; m_ord = 1'b0; m_busy = 1'b0;
        end else if (ld) begin
            m_up = a[AW-1:2]; m_lo = a[1:0]; m_cnt = '0; m_ord = ord; m_busy = 1'b1;
        end else if (adv && m_busy) begin
            m_cnt = m_cnt + 2'd1;
        end
        chk_all(tag);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        step(1'b0, '0, 1'b1, 1'b1, "R1 reset");
        step(1'b1, 20'hABCDE, 1'b1, 1'b1, "R1 reset with load");
        rst_n = 1'b1;

        // R6: advance while idle has no effect
        step(1'b0, '0, 1'b1, 1'b1, "R6 idle advance");
        step(1'b0, '0, 1'b1, 1'b0, "R6 idle advance");

        // R3/R4/R10: full bursts from every start, both orders, plus wrap (R7)
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                step(1'b1, {18'h2A55A, 2'(s)}, 1'b0, 1'(o), "R2 load");
                for (int b = 0; b < 5; b++)
                    step(1'b0, 20'h0, 1'b1, 1'(o), o ? "R3 interleave R7" : "R4 linear R7");
            end
        end

        // R5: extreme upper patterns held through a burst
        step(1'b1, 20'hFFFFD, 1'b0, 1'b0, "R5 load ones");
        for (int b = 0; b < 4; b++) step(1'b0, '0, 1'b1, 1'b0, "R5 upper held");
        step(1'b1, 20'hAAAAB, 1'b0, 1'b1, "R5 load alt");
        for (int b = 0; b < 3; b++) step(1'b0, 20'h55555, 1'b1, 1'b1, "R5 upper held");

        // R8: load beats advance on the same edge, mid-burst
        step(1'b1, 20'h12345, 1'b1, 1'b1, "R8 load+advance");
        step(1'b0, '0, 1'b1, 1'b1, "R8 after");

        // R9: order flips mid-burst are ignored
        step(1'b1, 20'h00001, 1'b0, 1'b0, "R9 load linear");
        step(1'b0, '0, 1'b1, 1'b1, "R9 flip order");
        step(1'b0, '0, 1'b1, 1'b1, "R9 flip order");
        step(1'b0, '0, 1'b1, 1'b1, "R9 flip order");

        // R2: back-to-back loads
        step(1'b1, 20'h00003, 1'b0, 1'b1, "R2 b2b");
        step(1'b1, 20'hFEDC2, 1'b0, 1'b0, "R2 b2b");

        // Random mix checked against the model (R2 R3 R4 R6 R8 R9)
        for (int i = 0; i < 3000; i++) begin
            logic ld, adv, ord;
            ld  = ($urandom % 5) == 0;
            adv = ($urandom % 4) != 0;
            ord = 1'($urandom);
            step(ld, AW'($urandom), adv, ord, "R3 R4 random");
        end

        // R1: reset in mid-burst
        rst_n = 1'b0;
        step(1'b0, '0, 1'b1, 1'b1, "R1 reset mid-burst");
        rst_n = 1'b1;
        step(1'b0, '0, 1'b1, 1'b1, "R1 idle after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule